// File: doc/BRIEF.md
# SDRAM Burst-Read Command Sequencer

This block serves one read request at a time to an SDRAM space. It never programs an SDRAM burst. An access wider than the external data bus becomes a chain of single-beat reads. The chain opens the row with an ACTIVE command, issues plain READs for every beat but the final one, and closes with a READ carrying auto-precharge. The column advances by the bus width in bytes on each beat.

Each read returns its data a fixed two clocks after the command. The block tags every issued read, captures its beat from the data pins and hands complete 32-bit words to the requester with a last-word flag. On a 16-bit bus, accesses of 32 bits or more are built from pairs of half-words.

After the auto-precharge read, a per-bank down-counter keeps that bank closed to new requests for a programmable number of cycles. Requests to the other banks can still be accepted straight away.

Top module: `sdram_rd_seq`

## Requirements
- R1: After reset, `sd_cmd` is NOP (code 0), `rsp_valid` is low, and `req_ready` is high for every bank.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. In the next cycle `sd_cmd` shows ACTIVE (code 1), with the request's bank on `sd_bank` and its row on `sd_addr`.
- R3: The number of read commands depends on `req_size` (0 = byte, 1 = half-word, 2 = word, 3 = 16-byte line, 4 = 128-byte block). With `cfg_bus32`=0 (16-bit bus) the counts are 1, 1, 2, 8, 64. With `cfg_bus32`=1 (32-bit bus) they are 1, 1, 1, 4, 32.
- R4: The read commands occupy consecutive cycles, starting the cycle after ACTIVE. Every one except the final is READ (code 2). The final one is READ with auto-precharge (code 3). The cycle after it shows NOP.
- R5: The first read carries `req_col` on `sd_addr`. Each later read adds 2 (16-bit bus) or 4 (32-bit bus), modulo the column width. `sd_bank` does not change during the transfer.
- R6: If the auto-precharge read is in cycle t, `req_ready` stays low for a request to the same bank in cycles t+1 through t+`cfg_trp`+1, and rises in cycle t+`cfg_trp`+2 if the sequencer is idle. No command is ever issued to a bank that is in its wait window.
- R7: A request to a different bank, made in the cycle right after the auto-precharge read, sees `req_ready` high and is accepted in that cycle.
- R8: The beat for a read issued in cycle c is sampled from `sd_dq` at the rising edge that ends cycle c+2. On the 32-bit bus each beat gives one response word, on `rsp_data` with `rsp_valid` high, in cycle c+3.
- R9: On the 16-bit bus, word, line and block accesses pair their beats: the earlier beat fills bits 15:0 and the later one bits 31:16, with one response per pair. Byte and half-word accesses return `sd_dq[15:0]` in bits 15:0 with bits 31:16 zero.
- R10: A transfer gives 1, 1, 1, 4 or 32 response words for sizes 0 to 4. `rsp_last` is high only with the final word.
- R11: `cfg_bus32` and `cfg_trp` are captured when the request is accepted. Changing them during the transfer has no effect on its commands, addresses or data.
- R12: While a transfer is issuing commands, `req_ready` is low for every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted for `req_bank` |
| req_bank | input | BANK_W (2) | Target bank |
| req_row | input | ROW_W (13) | Row address |
| req_col | input | COL_W (10) | Starting column address |
| req_size | input | 3 | Access size code 0..4 |
| cfg_bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_trp | input | TRP_W (2) | Precharge wait, cycles minus one |
| sd_cmd | output | 2 | 0 NOP, 1 ACTIVE, 2 READ, 3 READ with auto-precharge |
| sd_bank | output | BANK_W (2) | Bank of the current command |
| sd_addr | output | ADDR_W (13) | Row on ACTIVE, column on reads |
| sd_dq | input | 32 | Read data from the SDRAM |
| rsp_valid | output | 1 | Response word valid |
| rsp_last | output | 1 | Final word of the transfer |
| rsp_data | output | 32 | Assembled response word |

## Verification
The assertions assume that the SDRAM returns each beat exactly two clocks after its read command. They also assume that `req_bank` addresses one of the existing banks.

The bench responder stays inside both assumptions. It watches `sd_cmd` and drives `sd_dq` two cycles later with a pattern built from the bank and column. The bench only ever uses banks 0 to 3.

Configuration changes during a transfer are made on purpose, and only after acceptance. This is enough for the capture rule, since the block takes its settings at that point.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

    localparam int BEAT_W   = 7;   // holds counts up to 64
    localparam int DQ_W     = 32;
    localparam int HALF_W   = 16;
    localparam int READ_LAT = 2;

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_LINE  = 3'd3,
        SZ_BLOCK = 3'd4
    } size_e;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_RD   = 2'd2,
        CMD_RDAP = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_RD   = 2'd2
    } seq_st_e;

    // tag carried alongside each issued read until its data returns
    typedef struct packed {
        logic valid;
        logic emit;   // this beat completes a response word
        logic hi;     // beat lands in the upper half
        logic last;   // final beat of the transfer
        logic wide;   // 32-bit bus
    } rtag_t;

    function automatic logic [BEAT_W-1:0] beat_count(input logic [2:0] size,
                                                     input logic       bus32);
        logic [BEAT_W-1:0] n;
        case (size)
            SZ_BYTE:  n = BEAT_W'(1);
            SZ_HALF:  n = BEAT_W'(1);
            SZ_WORD:  n = bus32 ? BEAT_W'(1)  : BEAT_W'(2);
            SZ_LINE:  n = bus32 ? BEAT_W'(4)  : BEAT_W'(8);
            SZ_BLOCK: n = bus32 ? BEAT_W'(32) : BEAT_W'(64);
            default:  n = BEAT_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sdrd_bank_timer.sv
module sdrd_bank_timer #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int TRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] load_bank,
    input  logic [TRP_W-1:0]  load_trp,
    output logic [BANKS-1:0]  busy
);

    localparam int CNT_W = TRP_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2 ** TRP_W);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        assign hit = load && (load_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (hit) begin
                cnt_q <= CNT_W'(load_trp) + CNT_W'(1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end

        assign busy[b] = (cnt_q != '0);

        // a bank can only close again after its wait has run out
        AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
            hit |-> cnt_q == '0);  // R6
        AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= CNT_MAX);  // R6
    end

endmodule

// File: rtl/sdrd_cmd_fsm.sv
module sdrd_cmd_fsm
    import sdrd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int TRP_W  = 2,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [2:0]        req_size,
    input  logic              cfg_bus32,
    input  logic [TRP_W-1:0]  cfg_trp,
    input  logic              target_busy,
    output logic              req_ready,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              ap_fire,
    output logic [TRP_W-1:0]  ap_trp,
    output rtag_t             tag
);

    seq_st_e           st_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [BEAT_W-1:0] left_q;
    logic [BEAT_W-1:0] idx_q;
    logic              bus32_q;
    logic              pair_q;
    logic [TRP_W-1:0]  trp_q;

    logic              accept;
    logic [BEAT_W-1:0] n_beats;
    logic              last_beat;
    logic [COL_W-1:0]  col_step;

    assign accept    = (st_q == ST_IDLE) && req_valid && !target_busy;
    assign n_beats   = beat_count(req_size, cfg_bus32);
    assign last_beat = (left_q == '0);
    assign col_step  = bus32_q ? COL_W'(4) : COL_W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            left_q  <= '0;
            idx_q   <= '0;
            bus32_q <= 1'b0;
            pair_q  <= 1'b0;
            trp_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        bank_q  <= req_bank;
                        row_q   <= req_row;
                        col_q   <= req_col;
                        left_q  <= n_beats - BEAT_W'(1);
                        idx_q   <= '0;
                        bus32_q <= cfg_bus32;
                        pair_q  <= !cfg_bus32 && (n_beats != BEAT_W'(1));
                        trp_q   <= cfg_trp;
                        st_q    <= ST_ACT;
                    end
                end
                ST_ACT: begin
                    st_q <= ST_RD;
                end
                ST_RD: begin
                    col_q  <= col_q + col_step;
                    idx_q  <= idx_q + BEAT_W'(1);
                    left_q <= left_q - BEAT_W'(1);
                    if (last_beat) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd      = CMD_NOP;
        cmd_addr = '0;
        case (st_q)
            ST_ACT: begin
                cmd      = CMD_ACT;
                cmd_addr = ADDR_W'(row_q);
            end
            ST_RD: begin
                cmd      = last_beat ? CMD_RDAP : CMD_RD;
                cmd_addr = ADDR_W'(col_q);
            end
            default: ;
        endcase
    end

    assign req_ready = (st_q == ST_IDLE) && !target_busy;
    assign cmd_bank  = bank_q;
    assign ap_fire   = (st_q == ST_RD) && last_beat;
    assign ap_trp    = trp_q;

    always_comb begin
        tag.valid = (st_q == ST_RD);
        tag.last  = last_beat;
        tag.wide  = bus32_q;
        tag.hi    = pair_q && idx_q[0];
        tag.emit  = !pair_q || idx_q[0];
    end

    // paired transfers always close on the upper half of a pair
    AST_PAIR_CLOSED: assert property (@(posedge clk) disable iff (rst)
        ap_fire && pair_q |-> idx_q[0]);  // R9
    AST_ACT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_ACT |=> st_q == ST_RD);  // R2

endmodule

// File: rtl/sdrd_rd_pipe.sv
module sdrd_rd_pipe
    import sdrd_pkg::*;
#(
    parameter int LAT = READ_LAT
) (
    input  logic            clk,
    input  logic            rst,
    input  rtag_t           issue_tag,
    input  logic [DQ_W-1:0] dq,
    output logic            rsp_valid,
    output logic            rsp_last,
    output logic [DQ_W-1:0] rsp_data
);

    rtag_t              pipe_q [LAT];
    rtag_t              cap;
    logic [HALF_W-1:0]  lo_q;
    logic [DQ_W-1:0]    word;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LAT; s++) begin
                pipe_q[s] <= '0;
            end
        end else begin
            pipe_q[0] <= issue_tag;
            for (int s = 1; s < LAT; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign cap = pipe_q[LAT-1];

    always_comb begin
        if (cap.hi) begin
            word = {dq[HALF_W-1:0], lo_q};
        end else if (cap.wide) begin
            word = dq;
        end else begin
            word = {{(DQ_W-HALF_W){1'b0}}, dq[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cap.valid && cap.emit;
            rsp_last  <= cap.valid && cap.emit && cap.last;
            if (cap.valid) begin
                if (!cap.emit) begin
                    lo_q <= dq[HALF_W-1:0];
                end else begin
                    rsp_data <= word;
                end
            end
        end
    end

    AST_LAST_EMITS: assert property (@(posedge clk) disable iff (rst)
        cap.valid && cap.last |-> cap.emit);  // R10
    AST_HI_NARROW: assert property (@(posedge clk) disable iff (rst)
        cap.valid && cap.hi |-> !cap.wide);  // R9
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
        cap.valid && cap.hi |-> $past(cap.valid) && !$past(cap.emit));  // R9
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);  // R10

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdrd_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int TRP_W = 2,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [2:0]        req_size,
    input  logic              cfg_bus32,
    input  logic [TRP_W-1:0]  cfg_trp,
    output logic [1:0]        sd_cmd,
    output logic [BANK_W-1:0] sd_bank,
    output logic [ADDR_W-1:0] sd_addr,
    input  logic [DQ_W-1:0]   sd_dq,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DQ_W-1:0]   rsp_data
);

    cmd_e             cmd;
    logic [BANKS-1:0] busy;
    logic             target_busy;
    logic             ap_fire;
    logic [TRP_W-1:0] ap_trp;
    rtag_t            tag;

    assign target_busy = busy[req_bank];
    assign sd_cmd      = cmd;

    sdrd_cmd_fsm #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .TRP_W  (TRP_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_size    (req_size),
        .cfg_bus32   (cfg_bus32),
        .cfg_trp     (cfg_trp),
        .target_busy (target_busy),
        .req_ready   (req_ready),
        .cmd         (cmd),
        .cmd_bank    (sd_bank),
        .cmd_addr    (sd_addr),
        .ap_fire     (ap_fire),
        .ap_trp      (ap_trp),
        .tag         (tag)
    );

    sdrd_bank_timer #(
        .BANKS  (BANKS),
        .BANK_W (BANK_W),
        .TRP_W  (TRP_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (ap_fire),
        .load_bank (sd_bank),
        .load_trp  (ap_trp),
        .busy      (busy)
    );

    sdrd_rd_pipe #(
        .LAT (READ_LAT)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .issue_tag (tag),
        .dq        (sd_dq),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last),
        .rsp_data  (rsp_data)
    );

    AST_ACT_TO_READ: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_ACT |=> (cmd == CMD_RD || cmd == CMD_RDAP));  // R2
    AST_RDAP_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_RDAP |=> cmd == CMD_NOP);  // R4
    AST_NO_CMD_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_NOP |-> !busy[sd_bank]);  // R6
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_RDAP) |-> $stable(sd_bank));  // R5
    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_RDAP) && $past(cmd) == CMD_RD
        |-> ((sd_addr[COL_W-1:0] - $past(sd_addr[COL_W-1:0])) == COL_W'(2)
          || (sd_addr[COL_W-1:0] - $past(sd_addr[COL_W-1:0])) == COL_W'(4)));  // R5
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_NOP |-> !req_ready);  // R12

endmodule

// File: tb/sdram_rd_seq_tb.sv
module sdram_rd_seq_tb;

    typedef struct packed {
        logic [2:0] size;
        logic       bus32;
        logic [1:0] bank;
        logic [9:0] col;
        logic [1:0] trp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'd0, 10'h010, 2'd0},
        '{3'd1, 1'b1, 2'd1, 10'h020, 2'd1},
        '{3'd2, 1'b0, 2'd2, 10'h040, 2'd2},
        '{3'd2, 1'b1, 2'd3, 10'h044, 2'd3},
        '{3'd3, 1'b0, 2'd0, 10'h100, 2'd1},
        '{3'd3, 1'b1, 2'd1, 10'h200, 2'd0},
        '{3'd4, 1'b0, 2'd2, 10'h000, 2'd2},
        '{3'd4, 1'b1, 2'd3, 10'h080, 2'd3},
        '{3'd0, 1'b1, 2'd0, 10'h005, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [9:0]  req_col;
    logic [2:0]  req_size;
    logic        cfg_bus32;
    logic [1:0]  cfg_trp;
    logic [1:0]  sd_cmd;
    logic [1:0]  sd_bank;
    logic [12:0] sd_addr;
    logic [31:0] sd_dq;
    logic        rsp_valid;
    logic        rsp_last;
    logic [31:0] rsp_data;

    always #2 clk = ~clk;

    sdram_rd_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_size  (req_size),
        .cfg_bus32 (cfg_bus32),
        .cfg_trp   (cfg_trp),
        .sd_cmd    (sd_cmd),
        .sd_bank   (sd_bank),
        .sd_addr   (sd_addr),
        .sd_dq     (sd_dq),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last),
        .rsp_data  (rsp_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] exp_w [256];
    logic        exp_l [256];
    int          exp_n = 0;
    logic [31:0] got_w [256];
    logic        got_l [256];
    int          got_n = 0;
    logic [31:0] p0 = '0;
    logic [31:0] p1 = '0;

    function automatic logic [31:0] beat_data(input logic [1:0] b, input logic [9:0] c);
        return {8'hA5, 6'h0, b, 6'h0, c};
    endfunction

    function automatic int n_beats(input logic [2:0] s, input logic w);
        case (s)
            3'd2: return w ? 1 : 2;
            3'd3: return w ? 4 : 8;
            3'd4: return w ? 32 : 64;
            default: return 1;
        endcase
    endfunction

    function automatic int n_words(input logic [2:0] s);
        case (s)
            3'd3: return 4;
            3'd4: return 32;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // SDRAM responder (2-cycle latency) and response monitor
    always @(negedge clk) begin
        sd_dq = p1;
        p1 = p0;
        p0 = (sd_cmd == 2'd2 || sd_cmd == 2'd3) ? beat_data(sd_bank, sd_addr[9:0])
                                                 : 32'hDEAD_BEEF;
        if (!rst && rsp_valid && got_n < 256) begin
            got_w[got_n] = rsp_data;
            got_l[got_n] = rsp_last;
            got_n++;
        end
    end

    task automatic start_xfer(input logic [2:0] s, input logic w, input logic [1:0] b,
                              input logic [12:0] row, input logic [9:0] c,
                              input logic [1:0] trp, input bit flip, output int waited);
        int n;
        int nw;
        int bad_cmd;
        int bad_addr;
        logic [9:0] step;
        n    = n_beats(s, w);
        nw   = n_words(s);
        step = w ? 10'd4 : 10'd2;
        for (int j = 0; j < nw; j++) begin
            if (w)
                exp_w[exp_n] = beat_data(b, c + 10'(4 * j));
            else if (n == 1)
                exp_w[exp_n] = {16'h0, beat_data(b, c)[15:0]};
            else
                exp_w[exp_n] = {beat_data(b, c + 10'(4 * j + 2))[15:0],
                                beat_data(b, c + 10'(4 * j))[15:0]};
            exp_l[exp_n] = (j == nw - 1);
            exp_n++;
        end
        @(negedge clk);
        req_size = s; cfg_bus32 = w; req_bank = b; req_row = row; req_col = c;
        cfg_trp = trp; req_valid = 1'b1;
        waited = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(sd_cmd == 2'd1 && sd_bank == b && sd_addr == row, "R2 ACTIVE",
              {sd_cmd, sd_bank, sd_addr}, {2'd1, b, row});
        req_bank = b ^ 2'd1;
        #1;
        check(!req_ready, "R12 ready during transfer", req_ready, 0);
        if (flip) begin
            cfg_bus32 = !w;
            cfg_trp = ~trp;
        end
        bad_cmd = 0;
        bad_addr = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (sd_cmd != ((k == n - 1) ? 2'd3 : 2'd2)) bad_cmd++;
            if (sd_addr != {3'b0, c + 10'(k) * step} || sd_bank != b) bad_addr++;
        end
        check(bad_cmd == 0, "R3 R4 read command chain", bad_cmd, 0);
        check(bad_addr == 0, "R5 column/bank sequence", bad_addr, 0);
    endtask

    task automatic finish_xfer(input string tagname);
        int bad_d;
        int bad_l;
        repeat (6) @(negedge clk);
        #1;
        check(got_n == exp_n, {"R10 word count ", tagname}, got_n, exp_n);
        bad_d = 0;
        bad_l = 0;
        for (int i = 0; i < got_n && i < exp_n; i++) begin
            if (got_w[i] !== exp_w[i]) begin
                if (bad_d == 0)
                    $display("FAIL R8 R9 %s word %0d actual=%0h expected=%0h",
                             tagname, i, got_w[i], exp_w[i]);
                bad_d++;
            end
            if (got_l[i] !== exp_l[i]) bad_l++;
        end
        n_chk++;
        if (bad_d != 0) n_bad++;
        check(bad_l == 0, {"R10 last flag ", tagname}, bad_l, 0);
        got_n = 0;
        exp_n = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int wt;
        rst = 1'b1; req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
        req_size = '0; cfg_bus32 = 1'b0; cfg_trp = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check(sd_cmd == 2'd0, "R1 cmd after reset", sd_cmd, 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        // table walk
        for (int v = 0; v < NV; v++) begin
            start_xfer(VECS[v].size, VECS[v].bus32, VECS[v].bank, 13'h0A00 + 13'(v),
                       VECS[v].col, VECS[v].trp, 1'b0, wt);
            @(negedge clk);
            req_bank = VECS[v].bank;
            #1;
            check(!req_ready, "R6 same bank blocked after RDAP", req_ready, 0);
            check(sd_cmd == 2'd0, "R4 NOP after RDAP", sd_cmd, 0);
            finish_xfer("table");
        end

        // R6 window edges and R8 latency
        for (int tr = 0; tr < 4; tr += 3) begin
            start_xfer(3'd0, 1'b1, 2'd2, 13'h0111, 10'h030, 2'(tr), 1'b0, wt);
            for (int i = 1; i <= tr + 2; i++) begin
                @(negedge clk);
                req_bank = 2'd2;
                #1;
                check(req_ready == (i == tr + 2), "R6 wait window", req_ready, i == tr + 2);
                if (i <= 3)
                    check(rsp_valid == (i == 3), "R8 response latency", rsp_valid, i == 3);
            end
            finish_xfer("window");
        end

        // R7 other bank accepted right after RDAP
        start_xfer(3'd3, 1'b1, 2'd0, 13'h0222, 10'h040, 2'd3, 1'b0, wt);
        start_xfer(3'd2, 1'b0, 2'd1, 13'h0333, 10'h080, 2'd0, 1'b0, wt);
        check(wt == 0, "R7 other bank wait cycles", wt, 0);
        finish_xfer("overlap");

        // R11 config changed mid-transfer
        start_xfer(3'd3, 1'b0, 2'd3, 13'h0444, 10'h120, 2'd0, 1'b1, wt);
        finish_xfer("R11 latched config");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule